// File: doc/BRIEF.md
# Six-Channel Prescaled Countdown Timer Bank

This block holds six independent down-counters behind a small memory-mapped register file. Each channel takes one of four external clock-enable strobes, divides it by a power of two and uses the result to step its counter down. When a running channel finds its counter already at zero, it reports an expiry. In periodic mode it then reloads from its interval. In one-shot mode it stops and clears its own run bit.

Expiries set bits in a shared pending register, which software clears by writing ones. A shared mask register gates each pending bit onto its own interrupt line. Register reads have no side effects and are combinational from the stored state. A register write occupies one clock cycle with `bus_we` high.

Top module: `tick_bank`

## Requirements
- R1: After reset the mask and pending registers read 0, every interval and count reads 0, every control register reads 0x04 (source 1, divide by 1, stopped, periodic), and all interrupt lines are low.
- R2: Register decode works as follows. Offset 0x00 is the interrupt mask and 0x04 is the pending register. Channel i (0..5) has its control register at 0x10*(i+1), its interval at +4 and its count at +8. Any other offset reads 0 and ignores writes, and so does a write to a count register.
- R3: The control register fields are: run bit 0, reload bit 1, source select bits [3:2], divide exponent bits [6:4], and one-shot bit 7 (1 = one-shot, 0 = periodic). A write stores all eight bits, and a read returns them.
- R4: A channel steps once for every 2^n strobes of its selected source, where n is the divide exponent. A control write restarts the divider.
- R5: A source whose bit is clear in the SRC_LIVE parameter (default: source 3 clear) never steps a channel.
- R6: Writing a channel's interval stores the reload value and also loads the counter with it.
- R7: A control write with the reload bit set loads the counter from the interval. While the run bit is clear, the counter holds its value.
- R8: Each step of a running channel decrements a nonzero count. A step that finds the count at zero is an expiry, and in periodic mode that step reloads the counter from the interval.
- R9: On a one-shot expiry, hardware clears the channel's run bit and the count stays at 0. Later strobes have no effect.
- R10: An expiry sets the channel's pending bit. Writing the pending register clears exactly the bits written as 1.
- R11: Interrupt line i is high exactly when both pending bit i and mask bit i are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| src_stb | input | 4 | Clock-enable strobes of the four sources |
| irq_o | output | 6 | Gated interrupt line per channel |

## Verification
The bench checks the expiry step. A design that raises pending on the step that reaches zero, rather than on the step that finds zero, shows its pending bit one strobe early. It checks that a divided channel ignores the first 2^n−1 strobes, where an exponent decoded off by one would move the count a step too soon or too late. It checks that a one-shot expiry reads back with the run bit cleared and then ignores further strobes, and that a dead source leaves its counter untouched. It also checks that pending writes clear only the bits written as 1, and that writes to count registers, holes in the map and a seventh slot change nothing that can be read.

// File: rtl/tick_bank_pkg.sv
// Package for the timer bank.
// Holds the control-register layout, the register offsets and the reset
// control value. Assumes an 8-bit byte offset with 16-byte channel slots.
package tick_bank_pkg;

    localparam int PRE_W = 3;   // divide-exponent field width
    localparam int SRC_N = 4;   // number of strobe sources
    localparam int SRC_W = 2;   // source-select field width

    // Control register, bit 7 down to bit 0
    typedef struct packed {
        logic             one_shot;  // bit 7
        logic [PRE_W-1:0] div_exp;   // bits 6:4
        logic [SRC_W-1:0] src_sel;   // bits 3:2
        logic             reload;    // bit 1
        logic             run;       // bit 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam ctrl_t CTRL_RST = '{one_shot: 1'b0, div_exp: '0,
                                   src_sel: 2'd1, reload: 1'b0, run: 1'b0};

    // Shared register offsets
    localparam logic [7:0] OFS_MASK = 8'h00;
    localparam logic [7:0] OFS_PEND = 8'h04;

    // Offsets inside a channel slot
    localparam logic [3:0] SUB_CTRL = 4'h0;
    localparam logic [3:0] SUB_INTV = 4'h4;
    localparam logic [3:0] SUB_CNT  = 4'h8;

endpackage

// File: rtl/tick_bank_prescale.sv
// Per-channel strobe divider.
// Picks one of SRC_N source strobes and emits one step for every 2^div_exp
// strobes of that source. A source marked dead in SRC_LIVE never steps.
// Assumes that each strobe is a single-cycle enable in the clk domain.
module tick_bank_prescale
    import tick_bank_pkg::*;
#(
    parameter logic [SRC_N-1:0] SRC_LIVE = 4'b0111
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] src_stb,
    input  logic [SRC_W-1:0] src_sel,
    input  logic [PRE_W-1:0] div_exp,
    input  logic             restart,
    output logic             step
);
    localparam int PC_W = (1 << PRE_W) - 1;

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_lim;
    logic            stb_sel;

    // Gate the selected strobe with the liveness of its source
    always_comb begin
        stb_sel = src_stb[src_sel] & SRC_LIVE[src_sel];
        pc_lim  = PC_W'((1 << div_exp) - 1);
        step    = stb_sel && (pc_q == pc_lim) && !restart;
    end

    // Strobe counter, cleared by a control write or by a step
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pc_q <= '0;
        end else if (stb_sel) begin
            pc_q <= (pc_q == pc_lim) ? '0 : pc_q + 1'b1;
        end
    end

    // With a divider of at least 2, two steps can never come back to back
    AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && div_exp != '0 && !restart) |=> !step); // R4

    // A dead source never produces a step
    AST_DEAD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (!SRC_LIVE[src_sel]) |-> !step); // R5

endmodule

// File: rtl/tick_bank_chan.sv
// One countdown channel: the control, interval and counter registers.
// A register write to this channel takes priority over a step in the same
// cycle. A step that finds the count at zero is an expiry.
module tick_bank_chan
    import tick_bank_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             intv_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             step,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] intv_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);
    logic ch_wr;

    // Expiry detection, suppressed while a write owns the channel
    always_comb begin
        ch_wr  = ctrl_we | intv_we;
        expire = step && ctrl_q.run && (cnt_q == '0) && !ch_wr;
    end

    // Register update: writes first, then countdown or expiry handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            intv_q <= '0;
            cnt_q  <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (wdata[1]) begin
                cnt_q <= intv_q;
            end
        end else if (intv_we) begin
            intv_q <= wdata;
            cnt_q  <= wdata;
        end else if (step && ctrl_q.run) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (ctrl_q.one_shot) begin
                ctrl_q.run <= 1'b0;
            end else begin
                cnt_q <= intv_q;
            end
        end
    end

    // One-shot expiry drops the run bit
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl_q.one_shot) |=> !ctrl_q.run); // R9

    // Periodic expiry reloads from the interval
    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !ctrl_q.one_shot) |=> (cnt_q == $past(intv_q))); // R8

    // A stopped channel that is not written holds its count
    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !ch_wr) |=> $stable(cnt_q)); // R7

    // A running step on a nonzero count moves it down by one
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ctrl_q.run && !ch_wr && cnt_q != '0)
        |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8

endmodule

// File: rtl/tick_bank_irq.sv
// Interrupt mask and pending registers with per-channel gating.
// Pending bits are set by expiry and cleared by writing ones. If a set and
// a clear land in the same cycle, the set wins.
module tick_bank_irq #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mask_we,
    input  logic           pend_we,
    input  logic [NCH-1:0] wbits,
    input  logic [NCH-1:0] expire,
    output logic [NCH-1:0] mask_q,
    output logic [NCH-1:0] pend_q,
    output logic [NCH-1:0] irq
);
    // Mask register, written as a whole
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= wbits;
        end
    end

    // Pending register: clear-by-one, with a new expiry taking priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~(pend_we ? wbits : '0)) | expire;
        end
    end

    // Gate each pending bit onto its own line
    always_comb begin
        irq = pend_q & mask_q;
    end

    // Every expiry is recorded on the following cycle
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (expire != '0) |=> ((pend_q & $past(expire)) == $past(expire))); // R10

    // Without an expiry or a write, pending bits never change
    AST_PEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (expire == '0 && !pend_we) |=> $stable(pend_q)); // R10

endmodule

// File: rtl/tick_bank.sv
// Top level of the timer bank: register decode, read mux and channel array.
// Reads have no side effects. A write is one cycle of bus_we. The channel slot
// is bus_addr[7:4]-1 and the register inside the slot is bus_addr[3:0].
module tick_bank
    import tick_bank_pkg::*;
#(
    parameter int               NCH      = 6,
    parameter int               CNT_W    = 32,
    parameter logic [SRC_N-1:0] SRC_LIVE = 4'b0111
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [3:0]  src_stb,
    output logic [5:0]  irq_o
);
    localparam int SLOT_W = 4;

    ctrl_t            ctrl_q [NCH];
    logic [CNT_W-1:0] intv_q [NCH];
    logic [CNT_W-1:0] cnt_q  [NCH];
    logic [NCH-1:0]   ctrl_we, intv_we, step, expire;
    logic [NCH-1:0]   mask_q, pend_q, irq;
    logic [SLOT_W-1:0] slot;
    logic [3:0]        sub;
    logic              mask_we, pend_we;

    // Split the offset and decode the write strobes
    always_comb begin
        slot    = bus_addr[7:4];
        sub     = bus_addr[3:0];
        mask_we = bus_we && (bus_addr == OFS_MASK);
        pend_we = bus_we && (bus_addr == OFS_PEND);
        for (int i = 0; i < NCH; i++) begin
            ctrl_we[i] = bus_we && (slot == SLOT_W'(i + 1)) && (sub == SUB_CTRL);
            intv_we[i] = bus_we && (slot == SLOT_W'(i + 1)) && (sub == SUB_INTV);
        end
    end

    // Read mux: shared registers, then channel slots, zero elsewhere
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_MASK) begin
            bus_rdata = 32'(mask_q);
        end else if (bus_addr == OFS_PEND) begin
            bus_rdata = 32'(pend_q);
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (slot == SLOT_W'(i + 1)) begin
                    case (sub)
                        SUB_CTRL: bus_rdata = 32'(ctrl_q[i]);
                        SUB_INTV: bus_rdata = 32'(intv_q[i]);
                        SUB_CNT:  bus_rdata = 32'(cnt_q[i]);
                        default:  bus_rdata = '0;
                    endcase
                end
            end
        end
    end

    // One divider and one counter per channel
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tick_bank_prescale #(
            .SRC_LIVE (SRC_LIVE)
        ) u_pre (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_stb (src_stb),
            .src_sel (ctrl_q[g].src_sel),
            .div_exp (ctrl_q[g].div_exp),
            .restart (ctrl_we[g]),
            .step    (step[g])
        );

        tick_bank_chan #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (ctrl_we[g]),
            .intv_we (intv_we[g]),
            .wdata   (bus_wdata[CNT_W-1:0]),
            .step    (step[g]),
            .ctrl_q  (ctrl_q[g]),
            .intv_q  (intv_q[g]),
            .cnt_q   (cnt_q[g]),
            .expire  (expire[g])
        );
    end

    tick_bank_irq #(
        .NCH (NCH)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (mask_we),
        .pend_we (pend_we),
        .wbits   (bus_wdata[NCH-1:0]),
        .expire  (expire),
        .mask_q  (mask_q),
        .pend_q  (pend_q),
        .irq     (irq)
    );

    assign irq_o = irq;

    // A line can only be high for a channel that is both pending and unmasked
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~(pend_q & mask_q)) == '0); // R11

endmodule

// File: tb/tick_bank_tb.sv
// Scoreboard bench for tick_bank. The driver pushes expected values,
// and a monitor compares them on the falling edge.
module tick_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_stb = '0;
    logic [5:0]  irq_o;

    always #2.5 clk = ~clk;  // 200 MHz

    tick_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_stb   (src_stb),
        .irq_o     (irq_o)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    wd_hit = 0;

    // Monitor: compare one queued expectation per falling edge
    always @(negedge clk) begin
        if (q.size() != 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = it.is_irq ? {26'b0, irq_o} : bus_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic irq_chk(input logic [5:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.is_irq = 1'b1; it.exp = {26'b0, e}; it.tag = tag;
        q.push_back(it);
    endtask

    // n single-cycle strobes on source s, seen at n consecutive edges
    task automatic pulse(input int s, input int n);
        @(posedge clk); #1;
        src_stb[s] = 1'b1;
        repeat (n) @(posedge clk);
        #1 src_stb = '0;
    endtask

    task automatic run_all();
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(8'h00, 0, "R1 mask");
        rd(8'h04, 0, "R1 pending");
        rd(8'h10, 32'h04, "R1 ctrl0");
        rd(8'h64, 0, "R1 intv5");
        rd(8'h38, 0, "R1 cnt2");
        irq_chk(6'h00, "R1 irq");
        // Channel 0: periodic on source 1
        wr(8'h14, 5);
        rd(8'h18, 5, "R6 interval write loads count");
        wr(8'h10, 32'h05);
        rd(8'h10, 32'h05, "R3 ctrl readback");
        pulse(1, 3);
        rd(8'h18, 2, "R8 decrement");
        pulse(1, 2);
        rd(8'h18, 0, "R8 reached zero");
        rd(8'h04, 0, "R8 no expiry on reaching zero");
        pulse(1, 1);
        rd(8'h04, 32'h01, "R10 expiry sets pending");
        rd(8'h18, 5, "R8 periodic reload");
        irq_chk(6'h00, "R11 masked line low");
        wr(8'h00, 32'h01);
        irq_chk(6'h01, "R11 unmasked line high");
        wr(8'h04, 32'h3E);
        rd(8'h04, 32'h01, "R10 zero bits do not clear");
        wr(8'h04, 32'h01);
        rd(8'h04, 0, "R10 one clears");
        irq_chk(6'h00, "R11 line drops");
        wr(8'h10, 32'h04);
        // Channel 1: divide by 4 on source 0
        wr(8'h24, 3);
        wr(8'h20, 32'h21);
        pulse(0, 4);
        rd(8'h28, 2, "R4 one step per 4 strobes");
        pulse(0, 3);
        rd(8'h28, 2, "R4 three strobes no step");
        pulse(0, 1);
        rd(8'h28, 1, "R4 fourth strobe steps");
        wr(8'h20, 32'h20);
        // Channel 2: one-shot on source 1
        wr(8'h34, 2);
        wr(8'h30, 32'h85);
        pulse(1, 3);
        rd(8'h04, 32'h04, "R10 one-shot pending");
        rd(8'h30, 32'h84, "R9 run bit cleared");
        rd(8'h38, 0, "R9 count at zero");
        wr(8'h04, 32'h04);
        pulse(1, 2);
        rd(8'h04, 0, "R9 no further expiry");
        rd(8'h38, 0, "R9 count holds");
        // Channel 3: dead source 3
        wr(8'h44, 4);
        wr(8'h40, 32'h0D);
        pulse(3, 5);
        rd(8'h48, 4, "R5 dead source no step");
        // Channel 4: stop and reload
        wr(8'h54, 7);
        wr(8'h50, 32'h05);
        pulse(1, 3);
        rd(8'h58, 4, "R7 running count");
        wr(8'h50, 32'h04);
        pulse(1, 2);
        rd(8'h58, 4, "R7 stopped holds");
        wr(8'h50, 32'h06);
        rd(8'h58, 7, "R7 reload bit loads interval");
        // Decode holes
        wr(8'h58, 99);
        rd(8'h58, 7, "R2 count write ignored");
        wr(8'h0C, 32'hFF);
        rd(8'h0C, 0, "R2 hole reads zero");
        wr(8'h70, 32'h55);
        rd(8'h70, 0, "R2 seventh slot ignored");
        rd(8'h5C, 0, "R2 slot hole reads zero");
        rd(8'h00, 32'h01, "R2 hole write left mask");
        // Channel 5: last slot, gated line
        wr(8'h64, 1);
        wr(8'h60, 32'h05);
        wr(8'h00, 32'h20);
        pulse(1, 2);
        rd(8'h04, 32'h20, "R10 channel 5 pending");
        irq_chk(6'h20, "R11 channel 5 line");
        wr(8'h00, 32'h01);
        irq_chk(6'h00, "R11 remask drops line");
        repeat (3) @(posedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                wd_hit = 1;
            end
        join_any
        disable fork;
        repeat (2) @(posedge clk);
        if (wd_hit) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule